// File: doc/BRIEF.md
# Standby Input Gate for a Synchronous Memory

This block sits between a host and a synchronous memory core and turns an asynchronous, active-high standby request into a clean, clock-aligned sleep state. The request is resynchronised through two flip-flops. Once the synchronised request is high, every clocked control strobe headed for the core is forced to its idle level. The data output drivers are turned off, and the core is told it may enter retention. When the request drops, the strobes are released again after the same two-clock path.

The core keeps its contents for the whole standby period, and the standby lasts exactly as long as the request stays high. An access that is still in progress when gating begins may be lost. The block therefore raises a one-cycle flag at the moment of entry if the core reports an access in flight. A one-cycle strobe marks the first cycle in which inputs are passed through again.

Top module: `sleep_gate_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ignored_o`, `retain_o`, `wake_o` and `abort_o` are all 0.
- R2: If `sleep_req` is high at clock edge k, `ignored_o` is high after edge k+1. Inputs are therefore blanked no later than two clock periods after the request rises.
- R3: If `sleep_req` is low at clock edge k, `ignored_o` is low after edge k+1. Sampling therefore resumes no later than two clock periods after the request falls.
- R4: While `ignored_o` is 1, `cs_n_o`, `adv_n_o` and every bit of `bw_n_o` are held at 1 (idle, active-low) whatever their inputs are.
- R5: While `ignored_o` is 0, `cs_n_o`, `adv_n_o` and `bw_n_o` follow `cs_n_i`, `adv_n_i` and `bw_n_i` in the same cycle.
- R6: `dq_drive_o` is 1 exactly when `oe_n_i` is 0 and `ignored_o` is 0, so the data outputs are high impedance throughout standby.
- R7: `retain_o` is 1 exactly in the cycles where `ignored_o` is 1 and was also 1 in the previous cycle. It therefore rises one cycle after blanking starts and falls together with it.
- R8: `wake_o` is 1 for exactly one cycle: the first cycle in which `ignored_o` is 0 after having been 1.
- R9: `abort_o` is 1 only in the first cycle of a blanking period, and only when `busy_i` is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Asynchronous standby request, active high |
| cs_n_i | input | 1 | Chip select from host, active low |
| adv_n_i | input | 1 | New-address load strobe from host, active low |
| bw_n_i | input | BYTES | Byte write enables from host, active low |
| oe_n_i | input | 1 | Output enable from host, active low |
| busy_i | input | 1 | Core reports an access in flight |
| cs_n_o | output | 1 | Gated chip select to core |
| adv_n_o | output | 1 | Gated address load strobe to core |
| bw_n_o | output | BYTES | Gated byte write enables to core |
| dq_drive_o | output | 1 | Data output driver enable |
| ignored_o | output | 1 | Inputs are currently blanked |
| retain_o | output | 1 | Core may enter retention |
| wake_o | output | 1 | One-cycle strobe on return to active |
| abort_o | output | 1 | One-cycle flag: access in flight at sleep entry |

## Verification
The latency assertions assume that `sleep_req` meets setup and hold at the clock edge. Only then does the value the first synchroniser flop captures equal the sampled level. They also assume that `oe_n_i` and `busy_i` change only between edges. The bench meets these assumptions by changing every input, the request included, on the falling clock edge. Its request patterns include long holds, single-cycle pulses and per-cycle random toggling. Together these cover both latency bounds, back-to-back entry and exit, and entries with and without an access in flight.

// File: rtl/sleep_gate_ctrl.sv
module sleep_gate_ctrl #(
  parameter int BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             cs_n_i,
  input  logic             adv_n_i,
  input  logic [BYTES-1:0] bw_n_i,
  input  logic             oe_n_i,
  input  logic             busy_i,
  output logic             cs_n_o,
  output logic             adv_n_o,
  output logic [BYTES-1:0] bw_n_o,
  output logic             dq_drive_o,
  output logic             ignored_o,
  output logic             retain_o,
  output logic             wake_o,
  output logic             abort_o
);

  logic req_s1, req_s2, req_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
      req_d  <= 1'b0;
    end else begin
      req_s1 <= sleep_req;
      req_s2 <= req_s1;
      req_d  <= req_s2;
    end
  end

  assign ignored_o  = req_s2;
  assign retain_o   = req_s2 & req_d;
  assign wake_o     = req_d & ~req_s2;
  assign abort_o    = req_s2 & ~req_d & busy_i;

  assign cs_n_o     = cs_n_i  | req_s2;
  assign adv_n_o    = adv_n_i | req_s2;
  assign bw_n_o     = bw_n_i  | {BYTES{req_s2}};
  assign dq_drive_o = ~oe_n_i & ~req_s2;

  AST_ENTRY_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && sleep_req && $past(sleep_req)) |=> ignored_o); // R2
  AST_EXIT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !sleep_req && !$past(sleep_req)) |=> !ignored_o); // R3
  AST_STROBES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ignored_o |-> (cs_n_o && adv_n_o && (&bw_n_o) && !dq_drive_o)); // R4
  AST_RETAIN_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ignored_o) |-> !retain_o); // R7
  AST_WAKE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o); // R8
  AST_ABORT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (ignored_o && busy_i && !$past(ignored_o))); // R9

endmodule

// File: tb/test_sleep_gate_ctrl.sv
module test_sleep_gate_ctrl;
  localparam int BYTES = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, cs_n_i = 1'b1, adv_n_i = 1'b1, oe_n_i = 1'b1, busy_i = 1'b0;
  logic [BYTES-1:0] bw_n_i = '1;
  logic cs_n_o, adv_n_o, dq_drive_o, ignored_o, retain_o, wake_o, abort_o;
  logic [BYTES-1:0] bw_n_o;

  int checks = 0, errors = 0;
  bit hist[$];
  int aborts_seen = 0, wakes_seen = 0;

  always #2 clk = ~clk;

  sleep_gate_ctrl #(.BYTES(BYTES)) i_sleep_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .cs_n_i(cs_n_i), .adv_n_i(adv_n_i),
    .bw_n_i(bw_n_i), .oe_n_i(oe_n_i), .busy_i(busy_i), .cs_n_o(cs_n_o), .adv_n_o(adv_n_o),
    .bw_n_o(bw_n_o), .dq_drive_o(dq_drive_o), .ignored_o(ignored_o), .retain_o(retain_o),
    .wake_o(wake_o), .abort_o(abort_o));

  // reference: history of request levels seen at each rising edge, newest first
  always @(posedge clk) begin
    if (!rst_n) hist.delete();
    else begin
      hist.push_front(sleep_req);
      if (hist.size() > 4) void'(hist.pop_back());
    end
  end

  function automatic bit h(int i);
    return (hist.size() > i) ? hist[i] : 1'b0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit ign, prev;
    ign  = h(1);
    prev = h(2);
    chk(ign ? "R2" : "R3", "ignored_o", ignored_o, ign);
    if (ign) begin
      chk("R4", "cs_n_o", cs_n_o, 1);
      chk("R4", "adv_n_o", adv_n_o, 1);
      chk("R4", "bw_n_o", bw_n_o, {BYTES{1'b1}});
    end else begin
      chk("R5", "cs_n_o", cs_n_o, cs_n_i);
      chk("R5", "adv_n_o", adv_n_o, adv_n_i);
      chk("R5", "bw_n_o", bw_n_o, bw_n_i);
    end
    chk("R6", "dq_drive_o", dq_drive_o, !oe_n_i && !ign);
    chk("R7", "retain_o", retain_o, ign && prev);
    chk("R8", "wake_o", wake_o, prev && !ign);
    chk("R9", "abort_o", abort_o, ign && !prev && busy_i);
    if (abort_o) aborts_seen++;
    if (wake_o) wakes_seen++;
  endtask

  task automatic drive_side();
    cs_n_i  = 1'($urandom);
    adv_n_i = 1'($urandom);
    bw_n_i  = BYTES'($urandom);
    oe_n_i  = 1'($urandom);
    busy_i  = 1'($urandom);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    drive_side();
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "ignored_o", ignored_o, 0);
    chk("R1", "retain_o", retain_o, 0);
    chk("R1", "wake_o", wake_o, 0);
    chk("R1", "abort_o", abort_o, 0);
    sleep_req = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 first cycle after reset: request high only one edge so far
    chk("R1", "ignored_o after reset", ignored_o, 0);
    compare_all();
    sleep_req = 1'b0;
    // long holds
    for (int seg = 0; seg < 20; seg++) begin
      for (int c = 0; c < 15; c++) begin
        @(negedge clk);
        compare_all();
        drive_side();
      end
      sleep_req = ~sleep_req;
    end
    // single-cycle pulses and two-cycle gaps
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      compare_all();
      drive_side();
      sleep_req = (c % 3 == 0);
    end
    // random toggling
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      compare_all();
      drive_side();
      sleep_req = ($urandom_range(0, 3) == 0) ? ~sleep_req : sleep_req;
    end
    chk("R9", "abort pulses observed", int'(aborts_seen > 0), 1);
    chk("R8", "wake pulses observed", int'(wakes_seen > 0), 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule